// File: doc/BRIEF.md
# GPIO Controller with Status Overrides

This block controls five general-purpose pins through two byte-wide registers. One register holds the output value for each pin. The other holds a direction bit for each pin and three enable bits. When an enable bit is set, a live internal status signal drives a pin in place of the software setting. The block registers an output-enable, an output level and a pull-up enable for each pin towards the pads. It also samples the pad levels so that software can read them back.

Two pins can be taken over. Pin 1 can show the bus-master state. Pin 0 can show either the opcode-fetch strobe or the bus-connected state, which is meant to drive an activity LED. The fetch display outranks the LED display. The LED display is also held off while an EEPROM autodownload is running. An override takes the pin even when the pin's direction bit makes it an input. While an override holds a pin, the pin is driven and its pull-up is off.

The register port is a single-cycle write strobe with an address and write data, plus a combinational read-data output. Address 0 selects the data register and address 1 selects the control register. Control register layout: bit 7 = master display enable, bit 6 = fetch display enable, bit 5 = LED display enable, bits 4..0 = direction of pins 4..0, where 1 means input.

Top module: `gpio_override_ctrl`

## Requirements
- R1: After reset, the control register reads 0x0F and the data register holds 0. Pins 3..0 are inputs (output-enable 0, pull-up 1). Pin 4 is an output (output-enable 1, pull-up 0) driving 0.
- R2: A pin that is not overridden follows its direction bit. Direction 1 gives output-enable 0 and pull-up 1. Direction 0 gives output-enable 1 and pull-up 0. On every pin at every cycle, the pull-up enable equals the inverse of the output-enable.
- R3: A pin that is not overridden and has direction 0 drives the stored data-register bit of the same index.
- R4: A read at address 0 returns, in bits 4..0, the sampled pad level for pins with direction 1 and the stored value for pins with direction 0. Bits 7..5 read as 0.
- R5: A write at address 0 stores bits 4..0 for every pin, including pins that are inputs at the time. A stored value for an input pin appears on that pin once the pin is made an output.
- R6: With control bit 7 set, pin 1 is driven (output-enable 1, pull-up 0). It is low while the bus-master flag is 1 and high while it is 0, whatever pin 1's direction and data bits are.
- R7: With control bit 6 set, pin 0 is driven. It is low while the opcode-fetch flag is 1 and high otherwise, even when pin 0's direction bit is 1.
- R8: With control bit 5 set, bit 6 clear and the autodownload-busy flag 0, pin 0 is driven. It is low while the bus-connected flag is 1 and high otherwise.
- R9: When control bits 6 and 5 are both set, the fetch display drives pin 0 and the bus-connected flag has no effect on it.
- R10: With control bit 5 set, bit 6 clear and the autodownload-busy flag 1, pin 0 reverts to its direction and data configuration.
- R11: A register write shows on the read data right after the clock edge that takes it. It reaches the pin outputs one edge later. A status-flag or pad change reaches the pin outputs or the read data one edge after it is applied.
- R12: A read at address 1 returns all eight bits last written to the control register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe, one write per cycle it is high |
| reg_addr | input | 1 | 0 selects the data register, 1 selects the control register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| bus_master | input | 1 | High while the device owns the bus |
| opcode_fetch | input | 1 | High while an internal opcode fetch is in progress |
| bus_connected | input | 1 | High while the device is connected on the bus |
| eeprom_busy | input | 1 | High while an EEPROM autodownload runs |
| pin_in | input | 5 | Pad input levels |
| pin_oe | output | 5 | Registered output-enable per pin |
| pin_out | output | 5 | Registered output level per pin |
| pin_pu | output | 5 | Registered pull-up enable per pin |

## Verification
Each register write is due on `reg_rdata` as soon as the edge that takes it has passed. The same write is due on `pin_oe`, `pin_out` and `pin_pu` one edge later. A change on a status flag or on `pin_in` is due one edge after it is applied. The bench applies stimulus and checks the outputs on the falling edge. At each falling edge it compares the outputs with a prediction it made one cycle earlier, from its own register model and the stimulus it applied. Each check therefore lands on the cycle where the registered result is due, and never on the edge where the result changes.

// File: rtl/gpo_pkg.sv
package gpo_pkg;
  parameter int unsigned PINS      = 5;
  parameter int unsigned REG_W     = 8;
  parameter int unsigned ME_BIT    = 7;
  parameter int unsigned FE_BIT    = 6;
  parameter int unsigned LED_BIT   = 5;
  parameter int unsigned FETCH_PIN = 0;
  parameter int unsigned MSTR_PIN  = 1;
  parameter logic [REG_W-1:0] CTRL_RST = 8'h0F;
  parameter logic ADDR_DATA = 1'b0;
  parameter logic ADDR_CTRL = 1'b1;

  typedef struct packed {
    logic oe;
    logic lvl;
    logic pu;
  } pin_drv_t;

  // pin under software control
  function automatic pin_drv_t soft_drive(input logic is_input, input logic value);
    pin_drv_t d;
    d.oe  = !is_input;
    d.lvl = value;
    d.pu  = is_input;
    return d;
  endfunction

  // pin taken over by an active-low status display
  function automatic pin_drv_t status_drive(input logic flag);
    pin_drv_t d;
    d.oe  = 1'b1;
    d.lvl = !flag;
    d.pu  = 1'b0;
    return d;
  endfunction

  // data register view: pad level for inputs, stored bit for outputs
  function automatic logic [PINS-1:0] data_view(input logic [PINS-1:0] dir,
                                                input logic [PINS-1:0] pad,
                                                input logic [PINS-1:0] stored);
    return (dir & pad) | (~dir & stored);
  endfunction
endpackage

// File: rtl/gpo_regfile.sv
module gpo_regfile
  import gpo_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] ctrl_q,
  output logic [PINS-1:0]  dout_q,
  output logic             wr_ctrl,
  output logic             wr_data
);
  assign wr_ctrl = wr && (addr == ADDR_CTRL);
  assign wr_data = wr && (addr == ADDR_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      dout_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata;
      if (wr_data) dout_q <= wdata[PINS-1:0];
    end
  end
endmodule

// File: rtl/gpo_in_sample.sv
module gpo_in_sample
  import gpo_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pad,
  output logic [PINS-1:0] pad_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pad_q <= '0;
    else        pad_q <= pad;
  end
endmodule

// File: rtl/gpo_pin_mux.sv
module gpo_pin_mux
  import gpo_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] ctrl,
  input  logic [PINS-1:0]  dout,
  input  logic             bus_master,
  input  logic             opcode_fetch,
  input  logic             bus_connected,
  input  logic             eeprom_busy,
  output logic             fetch_take,
  output logic             led_take,
  output logic             mstr_take,
  output logic [PINS-1:0]  oe_q,
  output logic [PINS-1:0]  lvl_q,
  output logic [PINS-1:0]  pu_q
);
  logic [PINS-1:0] dir;
  pin_drv_t        drv [PINS];

  assign dir        = ctrl[PINS-1:0];
  assign fetch_take = ctrl[FE_BIT];
  assign led_take   = ctrl[LED_BIT] && !ctrl[FE_BIT] && !eeprom_busy;
  assign mstr_take  = ctrl[ME_BIT];

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    if (i == FETCH_PIN) begin : g_fetch
      always_comb begin
        if (fetch_take)    drv[i] = status_drive(opcode_fetch);
        else if (led_take) drv[i] = status_drive(bus_connected);
        else               drv[i] = soft_drive(dir[i], dout[i]);
      end
    end else if (i == MSTR_PIN) begin : g_mstr
      always_comb begin
        if (mstr_take) drv[i] = status_drive(bus_master);
        else           drv[i] = soft_drive(dir[i], dout[i]);
      end
    end else begin : g_plain
      always_comb drv[i] = soft_drive(dir[i], dout[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        oe_q[i]  <= !CTRL_RST[i];
        lvl_q[i] <= 1'b0;
        pu_q[i]  <= CTRL_RST[i];
      end else begin
        oe_q[i]  <= drv[i].oe;
        lvl_q[i] <= drv[i].lvl;
        pu_q[i]  <= drv[i].pu;
      end
    end
  end
endmodule

// File: rtl/gpio_override_ctrl.sv
module gpio_override_ctrl
  import gpo_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             bus_master,
  input  logic             opcode_fetch,
  input  logic             bus_connected,
  input  logic             eeprom_busy,
  input  logic [PINS-1:0]  pin_in,
  output logic [PINS-1:0]  pin_oe,
  output logic [PINS-1:0]  pin_out,
  output logic [PINS-1:0]  pin_pu
);
  localparam int unsigned PAD_W = REG_W - PINS;

  logic [REG_W-1:0] ctrl_q;
  logic [PINS-1:0]  dout_q;
  logic [PINS-1:0]  pad_q;
  logic             wr_ctrl, wr_data;
  logic             fetch_take, led_take, mstr_take;

  gpo_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .ctrl_q(ctrl_q), .dout_q(dout_q), .wr_ctrl(wr_ctrl), .wr_data(wr_data)
  );

  gpo_in_sample u_samp (
    .clk(clk), .rst_n(rst_n), .pad(pin_in), .pad_q(pad_q)
  );

  gpo_pin_mux u_mux (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl_q), .dout(dout_q),
    .bus_master(bus_master), .opcode_fetch(opcode_fetch),
    .bus_connected(bus_connected), .eeprom_busy(eeprom_busy),
    .fetch_take(fetch_take), .led_take(led_take), .mstr_take(mstr_take),
    .oe_q(pin_oe), .lvl_q(pin_out), .pu_q(pin_pu)
  );

  always_comb begin
    if (reg_addr == ADDR_CTRL) reg_rdata = ctrl_q;
    else reg_rdata = {{PAD_W{1'b0}}, data_view(ctrl_q[PINS-1:0], pad_q, dout_q)};
  end
endmodule

// File: rtl/gpo_ctrl_checker.sv
module gpo_ctrl_checker
  import gpo_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [REG_W-1:0] ctrl_q,
  input logic [PINS-1:0]  dout_q,
  input logic             fetch_take,
  input logic             led_take,
  input logic             mstr_take,
  input logic             bus_master,
  input logic             opcode_fetch,
  input logic             bus_connected,
  input logic [PINS-1:0]  pin_oe,
  input logic [PINS-1:0]  pin_out,
  input logic [PINS-1:0]  pin_pu
);
  assert_pu_opposes_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pin_pu == ~pin_oe);

  assert_plain_pin_drives_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[PINS-1] |=> (pin_oe[PINS-1] && pin_out[PINS-1] == $past(dout_q[PINS-1])));

  assert_master_display_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[ME_BIT] |=> (pin_oe[MSTR_PIN] && !pin_pu[MSTR_PIN] &&
                        pin_out[MSTR_PIN] == !$past(bus_master)));

  assert_fetch_display_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[FE_BIT] |=> (pin_oe[FETCH_PIN] && pin_out[FETCH_PIN] == !$past(opcode_fetch)));

  assert_led_display_R8: assert property (@(posedge clk) disable iff (!rst_n)
    led_take |=> (pin_oe[FETCH_PIN] && pin_out[FETCH_PIN] == !$past(bus_connected)));

  assert_fetch_outranks_led_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_take |-> !led_take);

  assert_led_blocked_reverts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[LED_BIT] && !fetch_take && !led_take) |=>
      (pin_oe[FETCH_PIN] == !$past(ctrl_q[FETCH_PIN])));

  assert_take_flags_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fetch_take, led_take}));

  assert_master_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mstr_take |=> (pin_oe[MSTR_PIN] == !$past(ctrl_q[MSTR_PIN])));
endmodule

bind gpio_override_ctrl gpo_ctrl_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_q(ctrl_q), .dout_q(dout_q),
  .fetch_take(fetch_take), .led_take(led_take), .mstr_take(mstr_take),
  .bus_master(bus_master), .opcode_fetch(opcode_fetch), .bus_connected(bus_connected),
  .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu)
);

// File: tb/tb_gpio_override_ctrl.sv
module tb_gpio_override_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_addr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       bus_master = 1'b0, opcode_fetch = 1'b0, bus_connected = 1'b0, eeprom_busy = 1'b0;
  logic [4:0] pin_in = 5'h00;
  logic [4:0] pin_oe, pin_out, pin_pu;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // bench model
  logic [7:0]  m_ctrl = 8'h0F;
  logic [4:0]  m_data = 5'h00;
  logic [4:0]  m_pad  = 5'h00;
  logic [14:0] want   = {5'b10000, 5'b00000, 5'b01111};
  logic [7:0]  want_rd = 8'h00;

  always #10 clk = ~clk;

  gpio_override_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bus_master(bus_master), .opcode_fetch(opcode_fetch),
    .bus_connected(bus_connected), .eeprom_busy(eeprom_busy),
    .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu)
  );

  // expected {oe, out, pu} from the requirement text
  function automatic logic [14:0] predict(input logic [7:0] c, input logic [4:0] d,
                                          input logic bm, input logic fch,
                                          input logic conn, input logic busy);
    logic [4:0] oe, lv, pu;
    for (int p = 0; p < 5; p++) begin
      logic is_in;
      is_in = c[p];
      oe[p] = ~is_in; lv[p] = d[p]; pu[p] = is_in;
      if (p == 1 && c[7]) begin oe[p] = 1; lv[p] = ~bm; pu[p] = 0; end
      if (p == 0) begin
        if (c[6]) begin oe[p] = 1; lv[p] = ~fch; pu[p] = 0; end
        else if (c[5] && !busy) begin oe[p] = 1; lv[p] = ~conn; pu[p] = 0; end
      end
    end
    return {oe, lv, pu};
  endfunction

  function automatic logic [7:0] predict_read(input logic a);
    logic [7:0] r;
    r = 8'h00;
    if (a) r = m_ctrl;
    else for (int p = 0; p < 5; p++) r[p] = m_ctrl[p] ? m_pad[p] : m_data[p];
    return r;
  endfunction

  function automatic string pin_tag(input int p);
    if (p == 1 && m_ctrl[7]) return "R6";
    if (p == 0 && m_ctrl[6]) return (m_ctrl[5] ? "R9" : "R7");
    if (p == 0 && m_ctrl[5]) return (eeprom_busy ? "R10" : "R8");
    return (m_ctrl[p] ? "R2" : "R3");
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Called at a falling edge; tags come from the model state of the previous cycle.
  logic [7:0] tag_ctrl = 8'h0F;
  task automatic check_outputs(input string ovr);
    logic [7:0] save;
    save = m_ctrl;
    m_ctrl = tag_ctrl;
    for (int p = 0; p < 5; p++) begin
      string t;
      t = (ovr != "") ? ovr : pin_tag(p);
      check(t, $sformatf("pin%0d oe/out/pu", p),
            {5'b0, pin_oe[p], pin_out[p], pin_pu[p]},
            {5'b0, want[10+p], want[5+p], want[p]});
    end
    m_ctrl = save;
    check((ovr != "") ? ovr : (reg_addr ? "R12" : "R4"), "reg_rdata", reg_rdata, want_rd);
  endtask

  task automatic step(input logic wr, input logic a, input logic [7:0] wd,
                      input logic [3:0] st, input logic [4:0] pads, input string ovr);
    check_outputs(ovr);
    reg_wr = wr; reg_addr = a; reg_wdata = wd;
    {bus_master, opcode_fetch, bus_connected, eeprom_busy} = st;
    pin_in = pads;
    tag_ctrl = m_ctrl;
    want = predict(m_ctrl, m_data, st[3], st[2], st[1], st[0]);
    if (wr && a)  m_ctrl = wd;
    if (wr && !a) m_data = wd[4:0];
    m_pad = pads;
    want_rd = predict_read(a);
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R11 actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1357));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state of pins and data readback
    step(0, 1, 8'h00, 4'b0000, 5'h00, "R1");
    // R1: control reads its reset value
    check_outputs("R1");
    // R5: data write while pins 3..0 are inputs; R11 latency
    step(1, 0, 8'h15, 4'b0000, 5'h0A, "R1");
    step(0, 0, 8'h00, 4'b0000, 5'h0A, "R11");
    // make all pins outputs: stored bits appear (R5, R3)
    step(1, 1, 8'h00, 4'b0000, 5'h0A, "R5");
    step(0, 0, 8'h00, 4'b0000, 5'h0A, "R11");
    step(0, 0, 8'h00, 4'b0000, 5'h0A, "R5");
    // R6: master display with pin 1 input, both flag values
    step(1, 1, 8'h82, 4'b1000, 5'h00, "R3");
    step(0, 1, 8'h00, 4'b1000, 5'h00, "");
    step(0, 1, 8'h00, 4'b0000, 5'h00, "R6");
    step(0, 1, 8'h00, 4'b1000, 5'h00, "R6");
    // R7 with pin 0 input, R9 fetch beats LED
    step(1, 1, 8'h61, 4'b0110, 5'h00, "R6");
    step(0, 1, 8'h00, 4'b0110, 5'h00, "");
    step(0, 1, 8'h00, 4'b0010, 5'h00, "R9");
    step(0, 1, 8'h00, 4'b0100, 5'h00, "R9");
    // R8 then R10 (autodownload blocks LED)
    step(1, 1, 8'h21, 4'b0010, 5'h01, "R9");
    step(0, 0, 8'h00, 4'b0010, 5'h01, "");
    step(0, 0, 8'h00, 4'b0011, 5'h01, "R8");
    step(0, 0, 8'h00, 4'b0011, 5'h00, "R10");
    step(1, 1, 8'h20, 4'b0011, 5'h00, "R10");
    step(0, 0, 8'h00, 4'b0011, 5'h00, "");
    step(0, 0, 8'h00, 4'b0001, 5'h00, "R10");
    // constrained random mix
    for (int n = 0; n < 800; n++) begin
      logic wr, a;
      logic [7:0] wd;
      wr = ($urandom_range(0, 9) < 3);
      a  = $urandom_range(0, 1);
      wd = 8'($urandom);
      step(wr, a, wd, 4'($urandom), 5'($urandom), "");
    end
    check_outputs("");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule